// File: doc/BRIEF.md
# Flash erase sequencer

This block turns a single erase request into the complete series of serial NOR flash command frames that the erase needs. It accepts either a sector request (a first sector number and a sector count) or a whole-device request. Before every erase it reads the device status until the busy flag is clear. It then issues a write-enable command in a chip-select frame of its own, and after that the erase command. A multi-sector request walks through consecutive sectors and runs the full poll, enable and erase series once for each sector. A one-cycle done pulse marks the end of the request.

The block talks to a byte-level SPI engine through a simple hold-until-acknowledged handshake, and it drives the chip select itself. The polling style is chosen per request. In exclusive-bus mode the block keeps chip select low and clocks filler bytes until the device reports idle. In shared-bus mode every status read is a short frame of its own. After a busy reply, chip select stays high for a programmable number of cycles so that other agents can use the bus.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held and after its release, chip select is high (deselected), and byte-valid, busy and done are all low.
- R2: The byte handshake works as follows. spi_valid_o is high only while spi_cs_n_o is low. spi_valid_o and spi_tx_o stay unchanged until the cycle in which spi_ack_i is high. spi_rx_i is taken in that same cycle.
- R3: A status poll begins with the byte 0x05. It is followed by filler bytes of 0xFF. Bit 0 of each byte returned for a filler is the busy flag: 1 means busy.
- R4: When shared_bus_i is low, the status read is a single frame: 0x05 followed by filler bytes, repeated until a reply has bit 0 clear. The frame then closes.
- R5: When shared_bus_i is high, every status read is the two-byte frame 0x05, 0xFF. After a busy reply, chip select stays high for exactly poll_gap_i+1 cycles before the next status frame starts.
- R6: After the idle status reply, a frame holding only 0x06 is sent. It is the frame directly before the erase frame.
- R7: A sector erase frame is 0x20 followed by three address bytes, most significant first. The address is the sector number shifted left by 12.
- R8: A chip erase frame is the single byte 0xC7.
- R9: A sector request with count N>0 erases sectors S, S+1, ... S+N-1 in that order. Each sector gets its own poll, write-enable and erase frames.
- R10: done_o is high for exactly one cycle. That cycle comes right after the cycle in which chip select rises at the end of the last erase frame. busy_o is high from the cycle after an accepted request up to that done cycle.
- R11: A request that arrives while busy_o is high is ignored. It produces no extra frame and no extra done pulse.
- R12: A sector request with count zero produces no frame. done_o is high in the following cycle, and busy_o stays low.
- R13: If both request inputs are high in the same idle cycle, the chip erase is performed.
- R14: Consecutive frames are separated by at least one cycle with chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_sector_i | input | 1 | Sector erase request, one cycle |
| req_chip_i | input | 1 | Whole-device erase request, one cycle |
| start_sector_i | input | SECW | First sector of a sector request |
| sector_count_i | input | CNTW | Number of sectors to erase |
| shared_bus_i | input | 1 | 1: release the bus between status reads |
| poll_gap_i | input | GAPW | Idle cycles after a busy status in shared mode |
| spi_ack_i | input | 1 | Byte engine finished the current byte |
| spi_rx_i | input | 8 | Byte received, valid with spi_ack_i |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_valid_o | output | 1 | Byte to transmit is presented |
| spi_tx_o | output | 8 | Byte to transmit |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | Request finished, one cycle |

## Verification
Two requests can land in the same cycle: the sector and chip request inputs. A request can also coincide with an operation that is already running. The bench raises both request lines on one idle edge and expects the frame stream of a chip erase with no address bytes. It also pulses both requests in the middle of a running shared-mode erase, and the reference frame queue must then match exactly, with no extra frame and a single done pulse. A per-frame comparison of bytes and chip-select gaps shows whether the wrong request won or the stray request leaked through.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_SECTOR = 8'h20;
  localparam logic [7:0] OP_WHOLE  = 8'hC7;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL_CMD,
    ST_POLL_RD,
    ST_POLL_WAIT,
    ST_SEP_WE,
    ST_WREN,
    ST_SEP_ER,
    ST_ER_OP,
    ST_ER_ADDR,
    ST_FIN
  } fes_state_t;

endpackage

// File: rtl/fes_sector_walker.sv
module fes_sector_walker #(
  parameter int SECW = 12,
  parameter int CNTW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [SECW-1:0] start_i,
  input  logic [CNTW-1:0] count_i,
  output logic [SECW-1:0] sector_o,
  output logic            last_o
);
  logic [SECW-1:0] sector_q, sector_d;
  logic [CNTW-1:0] remain_q, remain_d;
  logic            en;

  always_comb begin
    sector_d = sector_q;
    remain_d = remain_q;
    en       = load_i | step_i;
    if (load_i) begin
      sector_d = start_i;
      remain_d = count_i;
    end else if (step_i) begin
      sector_d = sector_q + SECW'(1);
      remain_d = remain_q - CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_q <= '0;
      remain_q <= '0;
    end else if (en) begin
      sector_q <= sector_d;
      remain_q <= remain_d;
    end
  end

  assign sector_o = sector_q;
  assign last_o   = (remain_q == CNTW'(1));
endmodule

// File: rtl/fes_gap_timer.sv
module fes_gap_timer #(
  parameter int GAPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [GAPW-1:0] len_i,
  output logic            expired_o
);
  logic [GAPW-1:0] cnt_q, cnt_d;
  logic            en;

  always_comb begin
    cnt_d = cnt_q;
    en    = 1'b0;
    if (load_i) begin
      cnt_d = len_i;
      en    = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - GAPW'(1);
      en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fes_seq_fsm.sv
module fes_seq_fsm #(
  parameter int IDXW       = 2,
  parameter int ADDR_BYTES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_sector_i,
  input  logic            req_chip_i,
  input  logic            count_zero_i,
  input  logic            shared_bus_i,
  input  logic            spi_ack_i,
  input  logic            status_busy_i,
  input  logic            walk_last_i,
  input  logic            gap_expired_i,
  input  logic [7:0]      addr_byte_i,
  output logic            walk_load_o,
  output logic            walk_step_o,
  output logic            gap_load_o,
  output logic [IDXW-1:0] addr_idx_o,
  output logic            spi_valid_o,
  output logic [7:0]      spi_tx_o,
  output logic            busy_o,
  output logic            done_o
);
  import fes_pkg::*;

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ADDR_BYTES - 1);

  fes_state_t      state_q, state_d;
  logic            chip_q, chip_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            done_q, done_d;

  always_comb begin
    state_d     = state_q;
    chip_d      = chip_q;
    idx_d       = idx_q;
    done_d      = 1'b0;
    walk_load_o = 1'b0;
    walk_step_o = 1'b0;
    gap_load_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_chip_i) begin
          chip_d  = 1'b1;
          state_d = ST_POLL_CMD;
        end else if (req_sector_i) begin
          if (count_zero_i) begin
            done_d = 1'b1;
          end else begin
            chip_d      = 1'b0;
            walk_load_o = 1'b1;
            state_d     = ST_POLL_CMD;
          end
        end
      end
      ST_POLL_CMD: if (spi_ack_i) state_d = ST_POLL_RD;
      ST_POLL_RD: begin
        if (spi_ack_i) begin
          if (!status_busy_i) begin
            state_d = ST_SEP_WE;
          end else if (shared_bus_i) begin
            gap_load_o = 1'b1;
            state_d    = ST_POLL_WAIT;
          end
        end
      end
      ST_POLL_WAIT: if (gap_expired_i) state_d = ST_POLL_CMD;
      ST_SEP_WE:    state_d = ST_WREN;
      ST_WREN:      if (spi_ack_i) state_d = ST_SEP_ER;
      ST_SEP_ER:    state_d = ST_ER_OP;
      ST_ER_OP: begin
        if (spi_ack_i) begin
          if (chip_q) begin
            state_d = ST_FIN;
          end else begin
            idx_d   = '0;
            state_d = ST_ER_ADDR;
          end
        end
      end
      ST_ER_ADDR: begin
        if (spi_ack_i) begin
          if (idx_q == LAST_IDX) state_d = ST_FIN;
          else                   idx_d   = idx_q + IDXW'(1);
        end
      end
      ST_FIN: begin
        if (chip_q || walk_last_i) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          walk_step_o = 1'b1;
          state_d     = ST_POLL_CMD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chip_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      chip_q  <= chip_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    spi_valid_o = 1'b1;
    case (state_q)
      ST_POLL_CMD: spi_tx_o = OP_STATUS;
      ST_POLL_RD:  spi_tx_o = FILL_BYTE;
      ST_WREN:     spi_tx_o = OP_WR_EN;
      ST_ER_OP:    spi_tx_o = chip_q ? OP_WHOLE : OP_SECTOR;
      ST_ER_ADDR:  spi_tx_o = addr_byte_i;
      default: begin
        spi_tx_o    = 8'h00;
        spi_valid_o = 1'b0;
      end
    endcase
  end

  assign addr_idx_o = idx_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int SECW         = 12,
  parameter int CNTW         = 13,
  parameter int GAPW         = 8,
  parameter int SECTOR_SHIFT = 12,
  parameter int ADDR_W       = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_sector_i,
  input  logic            req_chip_i,
  input  logic [SECW-1:0] start_sector_i,
  input  logic [CNTW-1:0] sector_count_i,
  input  logic            shared_bus_i,
  input  logic [GAPW-1:0] poll_gap_i,
  input  logic            spi_ack_i,
  input  logic [7:0]      spi_rx_i,
  output logic            spi_cs_n_o,
  output logic            spi_valid_o,
  output logic [7:0]      spi_tx_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDXW       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int SLOTS      = 1 << IDXW;

  logic [SECW-1:0]   cur_sector;
  logic              walk_last, walk_load, walk_step;
  logic              gap_load, gap_expired;
  logic [IDXW-1:0]   addr_idx;
  logic [ADDR_W-1:0] erase_addr;
  logic [7:0]        addr_slot [SLOTS];
  logic              unused_rx;

  assign unused_rx  = ^spi_rx_i[7:1];
  assign erase_addr = ADDR_W'(cur_sector) << SECTOR_SHIFT;

  for (genvar g = 0; g < SLOTS; g++) begin : g_addr_slot
    if (g < ADDR_BYTES) begin : g_real
      assign addr_slot[g] = erase_addr[ADDR_W-1-8*g -: 8];
    end else begin : g_pad
      assign addr_slot[g] = 8'h00;
    end
  end

  fes_sector_walker #(.SECW(SECW), .CNTW(CNTW)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (walk_load),
    .step_i   (walk_step),
    .start_i  (start_sector_i),
    .count_i  (sector_count_i),
    .sector_o (cur_sector),
    .last_o   (walk_last)
  );

  fes_gap_timer #(.GAPW(GAPW)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (gap_load),
    .len_i     (poll_gap_i),
    .expired_o (gap_expired)
  );

  fes_seq_fsm #(.IDXW(IDXW), .ADDR_BYTES(ADDR_BYTES)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_sector_i  (req_sector_i),
    .req_chip_i    (req_chip_i),
    .count_zero_i  (sector_count_i == '0),
    .shared_bus_i  (shared_bus_i),
    .spi_ack_i     (spi_ack_i),
    .status_busy_i (spi_rx_i[0]),
    .walk_last_i   (walk_last),
    .gap_expired_i (gap_expired),
    .addr_byte_i   (addr_slot[addr_idx]),
    .walk_load_o   (walk_load),
    .walk_step_o   (walk_step),
    .gap_load_o    (gap_load),
    .addr_idx_o    (addr_idx),
    .spi_valid_o   (spi_valid_o),
    .spi_tx_o      (spi_tx_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  assign spi_cs_n_o = ~spi_valid_o;
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_ack_i,
  input logic       spi_cs_n_o,
  input logic       spi_valid_o,
  input logic [7:0] spi_tx_o,
  input logic       busy_o,
  input logic       done_o
);
  // R2
  byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_valid_o |-> !spi_cs_n_o);

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_valid_o && !spi_ack_i) |=> (spi_valid_o && $stable(spi_tx_o)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (spi_cs_n_o && !spi_valid_o));
endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_ack_i   (spi_ack_i),
  .spi_cs_n_o  (spi_cs_n_o),
  .spi_valid_o (spi_valid_o),
  .spi_tx_o    (spi_tx_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/sim_flash_erase_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_sector_i, req_chip_i;
  logic [11:0] start_sector_i;
  logic [12:0] sector_count_i;
  logic        shared_bus_i;
  logic [7:0]  poll_gap_i;
  logic        spi_ack_i;
  logic [7:0]  spi_rx_i;
  logic        spi_cs_n_o, spi_valid_o, busy_o, done_o;
  logic [7:0]  spi_tx_o;

  always #4 clk = ~clk;

  flash_erase_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_sector_i(req_sector_i), .req_chip_i(req_chip_i),
    .start_sector_i(start_sector_i), .sector_count_i(sector_count_i),
    .shared_bus_i(shared_bus_i), .poll_gap_i(poll_gap_i), .spi_ack_i(spi_ack_i),
    .spi_rx_i(spi_rx_i), .spi_cs_n_o(spi_cs_n_o), .spi_valid_o(spi_valid_o),
    .spi_tx_o(spi_tx_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state: expected frames and device behaviour
  logic [7:0] exp_bytes[$];
  int         exp_len[$];
  int         exp_gap[$];
  logic [7:0] cur_frame[$];
  bit         in_frame = 0;
  int         hi_cnt = 0;
  int         cyc = 0;
  int         last_end_cyc = 0;
  int         done_cnt = 0;
  int         done_cyc = 0;
  int         wait_cnt = 0;
  int         busy_left = 0;
  int         per_busy = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string frame_tag(logic [7:0] b);
    case (b)
      8'h05:   return "R3";
      8'h06:   return "R6";
      8'h20:   return "R7";
      8'hC7:   return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic push_frame(int gap, logic [7:0] b[$]);
    foreach (b[i]) exp_bytes.push_back(b[i]);
    exp_len.push_back(b.size());
    exp_gap.push_back(gap);
  endtask

  // expected frames for one erase (poll, write enable, erase)
  task automatic build_one(bit shared, int n, int gap, bit chip, int sector, bit first);
    logic [7:0] f[$];
    int a;
    if (shared) begin
      for (int i = 0; i <= n; i++) begin
        f = {8'h05, 8'hFF};
        push_frame((i == 0) ? (first ? -1 : 1) : gap + 1, f);
      end
    end else begin
      f = {8'h05};
      for (int i = 0; i <= n; i++) f.push_back(8'hFF);
      push_frame(first ? -1 : 1, f);
    end
    f = {8'h06};
    push_frame(1, f);
    if (chip) begin
      f = {8'hC7};
    end else begin
      a = (sector % 4096) * 4096;
      f = {8'h20, 8'((a >> 16) & 255), 8'((a >> 8) & 255), 8'(a & 255)};
    end
    push_frame(1, f);
  endtask

  // bus monitor, byte engine and flash status model
  initial begin
    spi_ack_i = 1'b0;
    spi_rx_i  = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      if (done_o) begin
        done_cnt++;
        done_cyc = cyc;
      end
      if (!spi_cs_n_o && !in_frame) begin
        in_frame = 1;
        cur_frame.delete();
        if (exp_gap.size() == 0) begin
          check(0, "R11", "unexpected frame start", 1, 0);
        end else begin
          int g;
          g = exp_gap.pop_front();
          if (g > 1) check(hi_cnt == g, "R5", "deselect gap", hi_cnt, g);
          else if (g == 1) check(hi_cnt == 1, "R14", "frame gap", hi_cnt, 1);
        end
      end else if (spi_cs_n_o && in_frame) begin
        int len;
        bit ok;
        string tg;
        in_frame = 0;
        last_end_cyc = cyc;
        hi_cnt = 0;
        if (cur_frame.size() > 0 && (cur_frame[0] == 8'h20 || cur_frame[0] == 8'hC7))
          busy_left = per_busy;
        if (exp_len.size() > 0) begin
          len = exp_len.pop_front();
          tg = frame_tag(exp_bytes[0]);
          ok = (cur_frame.size() == len);
          for (int i = 0; i < len; i++) begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            if (ok && cur_frame[i] != e) begin
              ok = 0;
              check(0, tg, "frame byte", int'(cur_frame[i]), int'(e));
            end
          end
          if (ok) check(1, tg, "frame", 0, 0);
          else if (cur_frame.size() != len) check(0, tg, "frame length", cur_frame.size(), len);
        end
      end
      if (spi_cs_n_o) hi_cnt++;
      if (spi_ack_i) begin
        spi_ack_i = 1'b0;
        wait_cnt = 0;
      end else if (spi_valid_o) begin
        wait_cnt++;
        if (wait_cnt >= 2) begin
          if (cur_frame.size() > 0 && cur_frame[0] == 8'h05) begin
            spi_rx_i = (busy_left > 0) ? 8'h03 : 8'h02;
            if (busy_left > 0) busy_left--;
          end else begin
            spi_rx_i = 8'h00;
          end
          cur_frame.push_back(spi_tx_o);
          spi_ack_i = 1'b1;
        end
      end
    end
  end

  task automatic run_op(bit shared, int gap, int n, bit sec, bit chip, int sector,
                        int count, bit inject, string tag);
    int req_cyc;
    int t;
    shared_bus_i   = shared;
    poll_gap_i     = 8'(gap);
    busy_left      = n;
    per_busy       = n;
    start_sector_i = 12'(sector);
    sector_count_i = 13'(count);
    if (chip) build_one(shared, n, gap, 1, 0, 1);
    else for (int k = 0; k < count; k++) build_one(shared, n, gap, 0, sector + k, k == 0);
    done_cnt = 0;
    @(negedge clk);
    req_sector_i = sec;
    req_chip_i   = chip;
    req_cyc      = cyc;
    @(negedge clk);
    req_sector_i = 1'b0;
    req_chip_i   = 1'b0;
    if (sec && !chip && count == 0) begin
      check(done_o == 1'b1 && busy_o == 1'b0, "R12", "done next cycle, not busy",
            {done_o, busy_o}, 2);
    end else begin
      check(busy_o == 1'b1, "R10", "busy after request", busy_o, 1);
    end
    if (inject) begin
      repeat (20) @(negedge clk);
      start_sector_i = 12'h111;
      sector_count_i = 13'd1;
      req_sector_i = 1'b1;
      req_chip_i   = 1'b1;
      @(negedge clk);
      req_sector_i = 1'b0;
      req_chip_i   = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (30) @(negedge clk);
    check(done_cnt == 1, tag, "done pulse count", done_cnt, 1);
    check(exp_len.size() == 0, tag, "frames left unsent", exp_len.size(), 0);
    if (sec && !chip && count == 0)
      check(done_cyc == req_cyc + 1, "R12", "done cycle", done_cyc - req_cyc, 1);
    else
      check(done_cyc == last_end_cyc + 1, "R10", "done after last frame",
            done_cyc - last_end_cyc, 1);
    check(busy_o == 1'b0 && spi_cs_n_o == 1'b1, tag, "idle afterwards",
          {busy_o, spi_cs_n_o}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog: actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_sector_i = 1'b0;
    req_chip_i = 1'b0;
    start_sector_i = '0;
    sector_count_i = '0;
    shared_bus_i = 1'b0;
    poll_gap_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(spi_cs_n_o && !spi_valid_o && !busy_o && !done_o, "R1", "reset outputs",
          {spi_cs_n_o, spi_valid_o, busy_o, done_o}, 8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(spi_cs_n_o && !spi_valid_o && !busy_o && !done_o, "R1", "after reset",
          {spi_cs_n_o, spi_valid_o, busy_o, done_o}, 8);
    // R5 shared polling with gap, R6, R7 single sector
    run_op(1, 3, 2, 1, 0, 5, 1, 0, "R5");
    // R4 exclusive polling
    run_op(0, 0, 3, 1, 0, 12'hABC, 1, 0, "R4");
    // R8 chip erase, device already idle
    run_op(0, 0, 0, 0, 1, 0, 0, 0, "R8");
    // R9 consecutive sectors, zero gap
    run_op(1, 0, 1, 1, 0, 12'h7FD, 3, 0, "R9");
    // R12 zero count
    run_op(1, 2, 0, 1, 0, 9, 0, 0, "R12");
    // R11 requests while busy are ignored
    run_op(1, 5, 4, 1, 0, 12'h010, 1, 1, "R11");
    // R13 both requests together: chip erase wins
    run_op(0, 0, 1, 1, 1, 12'h222, 2, 0, "R13");
    // R2 exclusive multi sector with longer busy
    run_op(0, 0, 5, 1, 0, 12'hFFE, 2, 0, "R2");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule